// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Stored Condition Flags

This block computes one of sixteen operations on two 8-bit operands and presents the result combinationally in the same cycle. The operation set covers operand pass-through, bitwise inversion, addition with and without an incoming carry, subtraction, three bitwise logic operations, and six single-bit shifts (logical, arithmetic and circular, in each direction).

Four condition flags (zero, carry, negative, overflow) are kept in a register and change only at a rising clock edge while the flag-update enable is high. Each operation writes its own subset of the flags and leaves the others as they were. The stored carry is the carry input for the add-with-carry operation, so multi-byte sums can be chained one byte per cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: Code 0000 gives A, 0001 gives B, 0010 gives the inverse of A, 0011 the inverse of B, 0111 gives A AND B, 1000 A OR B and 1001 A XOR B.
- R2: Code 0100 gives A+B and code 0101 gives A+B plus the stored carry, both modulo 256. C takes the carry out of bit 7, and O is set when both operands have the same sign and the result sign differs from it.
- R3: Code 0110 gives A-B computed as A + NOT B + 1. C takes the carry out of that sum (1 means no borrow), and O is set when the operand signs differ and the result sign differs from A.
- R4: Code 1010 shifts A left one place filling 0 and C takes old bit 7; code 1011 shifts A right one place filling 0 and C takes old bit 0.
- R5: Code 1100 gives the same result and C as code 1010 and also sets O to (old bit 7 XOR old bit 6); code 1101 shifts right keeping bit 7 and C takes old bit 0.
- R6: Code 1110 rotates A left by one (bit 7 into bit 0) and code 1111 rotates A right by one (bit 0 into bit 7), neither involving the carry.
- R7: An updated Z is 1 exactly when the result is zero, and an updated N equals result bit 7.
- R8: Codes 0000-0011 and 0111-1001 and the rotates write only Z and N; codes 1010, 1011 and 1101 write Z, N and C; codes 0100, 0101, 0110 and 1100 write all four flags. Flags not written keep their value.
- R9: The flags change at the rising clock edge only when the flag-update enable is 1; with the enable at 0 they hold while the result still follows the inputs.
- R10: A synchronous active-high reset clears all four flags at the next rising edge.
- R11: Add-with-carry uses the carry held in the flag register in the current cycle, not a freshly computed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| flag_en | input | 1 | Allows the flags to update at the edge |
| op | input | 4 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 8 | Combinational operation result |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_n | output | 1 | Stored negative flag |
| flag_o | output | 1 | Stored overflow flag |

## Verification
The result is due in the same cycle the operands and code are applied, with no register on its path, while the flags are due one rising edge later. The bench drives inputs just after a falling edge, reads the result a nanosecond later, then reads the flags a nanosecond after the following rising edge. Because unwritten flags carry over, the vector table lists the full expected flag set after every step, which also checks the carry chain into add-with-carry.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_PASS_A = 4'h0,
        OP_PASS_B = 4'h1,
        OP_INV_A  = 4'h2,
        OP_INV_B  = 4'h3,
        OP_ADD    = 4'h4,
        OP_ADC    = 4'h5,
        OP_SUB    = 4'h6,
        OP_AND    = 4'h7,
        OP_OR     = 4'h8,
        OP_XOR    = 4'h9,
        OP_SHL    = 4'hA,
        OP_SHR    = 4'hB,
        OP_SAL    = 4'hC,
        OP_SAR    = 4'hD,
        OP_ROL    = 4'hE,
        OP_ROR    = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic o;
    } flag_t;

    // Which flags a given operation is allowed to write.
    function automatic flag_t write_mask(alu_op_e code);
        flag_t m;
        m = '{z: 1'b1, c: 1'b0, n: 1'b1, o: 1'b0};
        case (code)
            OP_ADD, OP_ADC, OP_SUB, OP_SAL: begin
                m.c = 1'b1;
                m.o = 1'b1;
            end
            OP_SHL, OP_SHR, OP_SAR: m.c = 1'b1;
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic is_adder_op(alu_op_e code);
        return (code == OP_ADD) || (code == OP_ADC) || (code == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         subtract,
    input  logic         use_cin,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = subtract ? ~opb : opb;
        c_eff = subtract ? 1'b1 : (use_cin & cin);
        wide  = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (opa[W-1] == b_eff[W-1]) && (sum[W-1] != opa[W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W = 8
) (
    input  alu_pkg::alu_op_e code,
    input  logic [W-1:0]     src,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             ovf
);
    import alu_pkg::*;

    always_comb begin
        res  = src;
        cout = 1'b0;
        ovf  = 1'b0;
        case (code)
            OP_SHL, OP_SAL: begin
                res  = {src[W-2:0], 1'b0};
                cout = src[W-1];
                ovf  = src[W-1] ^ src[W-2];
            end
            OP_SHR: begin
                res  = {1'b0, src[W-1:1]};
                cout = src[0];
            end
            OP_SAR: begin
                res  = {src[W-1], src[W-1:1]};
                cout = src[0];
            end
            OP_ROL: res = {src[W-2:0], src[W-1]};
            OP_ROR: res = {src[0], src[W-1:1]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  alu_pkg::flag_t mask,
    input  alu_pkg::flag_t next,
    output alu_pkg::flag_t held
);
    import alu_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (upd) begin
            held <= flag_t'((4'(mask) & 4'(next)) | (~4'(mask) & 4'(held)));
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flag_en,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_n,
    output logic         flag_o
);
    import alu_pkg::*;

    alu_op_e      code;
    logic [W-1:0] add_sum, sh_res;
    logic         add_c, add_o, sh_c, sh_o;
    flag_t        held, next, mask;

    assign code = alu_op_e'(op);

    alu_adder #(.W(W)) u_add (
        .opa(a), .opb(b),
        .subtract(code == OP_SUB),
        .use_cin(code == OP_ADC),
        .cin(held.c),
        .sum(add_sum), .cout(add_c), .ovf(add_o)
    );

    alu_shifter #(.W(W)) u_shift (
        .code(code), .src(a),
        .res(sh_res), .cout(sh_c), .ovf(sh_o)
    );

    always_comb begin
        case (code)
            OP_PASS_A: result = a;
            OP_PASS_B: result = b;
            OP_INV_A:  result = ~a;
            OP_INV_B:  result = ~b;
            OP_AND:    result = a & b;
            OP_OR:     result = a | b;
            OP_XOR:    result = a ^ b;
            OP_ADD, OP_ADC, OP_SUB: result = add_sum;
            default:   result = sh_res;
        endcase
    end

    always_comb begin
        next.z = (result == '0);
        next.n = result[W-1];
        next.c = is_adder_op(code) ? add_c : sh_c;
        next.o = is_adder_op(code) ? add_o : sh_o;
        mask   = write_mask(code);
    end

    alu_flag_reg u_flags (
        .clk(clk), .rst(rst), .upd(flag_en),
        .mask(mask), .next(next), .held(held)
    );

    assign flag_z = held.z;
    assign flag_c = held.c;
    assign flag_n = held.n;
    assign flag_o = held.o;
endmodule

// File: rtl/alu_flag_checker.sv
module alu_flag_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         flag_en,
    input logic [3:0]   op,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_n,
    input logic         flag_o
);
    logic [3:0] flags;
    assign flags = {flag_z, flag_c, flag_n, flag_o};

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (flags == 4'b0000));

    p_hold_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> $stable(flags));

    p_zero_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> (flag_z == ($past(result) == '0)));

    p_neg_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        flag_en |=> (flag_n == $past(result[W-1])));

    p_rotate_keeps_co_r8: assert property (@(posedge clk) disable iff (rst)
        (op[3:1] == 3'b111) |=> ($stable(flag_c) && $stable(flag_o)));

    p_logic_keeps_co_r8: assert property (@(posedge clk) disable iff (rst)
        ((op <= 4'h3) || (op >= 4'h7 && op <= 4'h9)) |=> ($stable(flag_c) && $stable(flag_o)));

    p_adc_uses_held_r11: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h5) |-> (result == W'(a + b + {{(W-1){1'b0}}, flag_c})));

    p_plain_add_r2: assert property (@(posedge clk) disable iff (rst)
        (op == 4'h4) |-> (result == W'(a + b)));
endmodule

bind alu_flag_unit alu_flag_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .flag_en(flag_en), .op(op), .a(a), .b(b),
    .result(result), .flag_z(flag_z), .flag_c(flag_c),
    .flag_n(flag_n), .flag_o(flag_o)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flag_en = 1'b0;
    logic [3:0] op = 4'h0;
    logic [7:0] a = 8'h00, b = 8'h00;
    logic [7:0] result;
    logic       flag_z, flag_c, flag_n, flag_o;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    alu_flag_unit uut (
        .clk(clk), .rst(rst), .flag_en(flag_en), .op(op), .a(a), .b(b),
        .result(result), .flag_z(flag_z), .flag_c(flag_c),
        .flag_n(flag_n), .flag_o(flag_o)
    );

    // {op, a, b, expected result, expected flags z c n o}; flags start at 0000
    localparam logic [31:0] VEC [0:22] = '{
        {4'h0, 8'h00, 8'h55, 8'h00, 4'b1000},
        {4'h1, 8'h00, 8'h80, 8'h80, 4'b0010},
        {4'h2, 8'hFF, 8'h00, 8'h00, 4'b1000},
        {4'h3, 8'h00, 8'h0F, 8'hF0, 4'b0010},
        {4'h4, 8'h7F, 8'h01, 8'h80, 4'b0011},
        {4'h4, 8'hFF, 8'h01, 8'h00, 4'b1100},
        {4'h5, 8'h10, 8'h20, 8'h31, 4'b0000},
        {4'h5, 8'h10, 8'h20, 8'h30, 4'b0000},
        {4'h6, 8'h05, 8'h03, 8'h02, 4'b0100},
        {4'h6, 8'h03, 8'h05, 8'hFE, 4'b0010},
        {4'h6, 8'h80, 8'h01, 8'h7F, 4'b0101},
        {4'h7, 8'hF0, 8'h3C, 8'h30, 4'b0101},
        {4'h8, 8'h00, 8'h00, 8'h00, 4'b1101},
        {4'h9, 8'hAA, 8'h55, 8'hFF, 4'b0111},
        {4'hA, 8'h81, 8'h00, 8'h02, 4'b0101},
        {4'hB, 8'h01, 8'h00, 8'h00, 4'b1101},
        {4'hC, 8'h40, 8'h00, 8'h80, 4'b0011},
        {4'hD, 8'h81, 8'h00, 8'hC0, 4'b0111},
        {4'hE, 8'h81, 8'h00, 8'h03, 4'b0101},
        {4'hF, 8'h01, 8'h00, 8'h80, 4'b0111},
        {4'hC, 8'hC0, 8'h00, 8'h80, 4'b0110},
        {4'h5, 8'h01, 8'h01, 8'h03, 4'b0000},
        {4'hB, 8'hFE, 8'h00, 8'h7F, 4'b0000}
    };

    function automatic string op_tag(input logic [3:0] c);
        case (c)
            4'h4, 4'h5: return "R2";
            4'h6:       return "R3";
            4'hA, 4'hB: return "R4";
            4'hC, 4'hD: return "R5";
            4'hE, 4'hF: return "R6";
            default:    return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [7:0] x, input logic [7:0] y,
                         input logic en);
        @(negedge clk);
        op = c; a = x; b = y; flag_en = en;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] flags8();
        return {4'b0, flag_z, flag_c, flag_n, flag_o};
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R10 flags after reset", flags8(), 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 23; i++) begin
            drive(VEC[i][31:28], VEC[i][27:20], VEC[i][19:12], 1'b1);
            check(op_tag(VEC[i][31:28]), result, VEC[i][11:4]);
            after_edge();
            check("R7/R8 flags", flags8(), {4'b0, VEC[i][3:0]});
        end

        // set carry and zero, then disabled update must hold them (R9)
        drive(4'h4, 8'hFF, 8'h01, 1'b1);
        after_edge();
        check("R2 carry set", flags8(), 8'h0C);
        drive(4'h5, 8'h00, 8'h00, 1'b0);
        check("R11 adc sees held carry", result, 8'h01);
        after_edge();
        check("R9 flags hold when disabled", flags8(), 8'h0C);

        // synchronous reset clears flags (R10)
        @(negedge clk);
        rst = 1'b1;
        after_edge();
        check("R10 reset clears", flags8(), 8'h00);
        @(negedge clk);
        rst = 1'b0;
        drive(4'h5, 8'h00, 8'h00, 1'b1);
        check("R11 adc after carry cleared", result, 8'h00);
        after_edge();
        check("R7 zero after adc", flags8(), 8'h08);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule